// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes packets arriving one byte at a time and stores them into buffers described by a ring of descriptors kept in system memory. A single word-wide memory master port is used for every access: descriptor reads, buffer writes and status write-back. Software supplies the ring base address and sets the current descriptor pointer. The block then works down the ring on its own. A packet that does not fit one buffer is spread over the descriptors that follow. The current pointer moves past each descriptor it consumes.

Every descriptor is two 32-bit words. The first word carries the flags and the buffer length, and the second carries the buffer address. The block writes the status of each chained descriptor as soon as that descriptor is finished. It writes the status of the first descriptor of the packet last. That final write hands the whole packet back to software, and a one-cycle interrupt pulse follows it.

Top module: `rxr_ring_writer`

## Requirements
- R1: A descriptor at address D has word0 at D and word1 (buffer address, word aligned) at D+4. In word0, bit 31 marks the descriptor as owned by the block, bit 30 means wrap to the ring base, bit 27 means the packet continues, and bits 12:0 give the buffer length in bytes. Status write-backs replace word0 with full byte enables.
- R2: If the ring base input is zero when a packet starts, the packet is consumed and discarded. There is no memory access and no interrupt, and the current pointer does not change.
- R3: If word0 of the current descriptor does not have bit 31 set, the packet is consumed and discarded. The block makes only that one read, writes nothing, raises no interrupt and leaves the pointer unchanged.
- R4: Each buffer receives the smaller of its length field and the bytes still to store. Packet byte k of a buffer goes to byte lane k mod 4 (bits 8*lane+7:8*lane) of the word at buffer+4*(k/4). A partial final word is written with only the used lanes enabled.
- R5: When a buffer is full and bytes remain, the block reads word0 of the next descriptor. The next descriptor is at the ring base if the wrap bit of the current one is set, and at the current address plus 8 otherwise. If the next descriptor is owned, the finished status is bit 27 set OR the byte count.
- R6: If that next descriptor is not owned, the finished status is the byte count alone with no flag bits. The rest of the packet is discarded, and the pointer moves to the unowned descriptor. The first-descriptor write and the interrupt still happen.
- R7: The last descriptor's status is its byte count plus the CRC size, with no flag bits. The CRC size is 2 when cfg_crc4_i is 0 and 4 when it is 1.
- R8: Status words for the second and later descriptors are written in ring order as each one finishes. The first descriptor's status is the last write of the packet. irq_o pulses for exactly one cycle after that write.
- R9: A packet longer than 8192 bytes is cut to its first 8192 bytes, and the excess bytes are discarded.
- R10: After a stored packet, cur_ptr_o points to the descriptor after the last one used. A write through cfg_cur_we_i takes effect only while the block is idle.
- R11: No byte is accepted while a memory request is outstanding, and only one packet is handled at a time. Bytes without a start marker that arrive while idle are discarded with no memory access.
- R12: A memory request, together with its address, write flag, data and byte enables, is held stable until mem_ready_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ring_base_i | input | 32 | Ring base address, zero disables storage |
| cfg_cur_we_i | input | 1 | Load the current descriptor pointer |
| cfg_cur_wdata_i | input | 32 | New current descriptor pointer |
| cfg_crc4_i | input | 1 | CRC size selection: 0 gives 2 bytes, 1 gives 4 bytes |
| cur_ptr_o | output | 32 | Current descriptor pointer |
| s_valid_i | input | 1 | Byte valid |
| s_data_i | input | 8 | Packet byte |
| s_sop_i | input | 1 | First byte of a packet |
| s_eop_i | input | 1 | Last byte of a packet |
| s_ready_o | output | 1 | Byte accepted when high together with valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Request completes this cycle |
| irq_o | output | 1 | One-cycle pulse when a packet has been stored |

## Verification
The bench sets up a ring in which one packet chains over three descriptors and wraps back to the base. It then checks that the two chained statuses are written before the first one. A design that committed the first descriptor early would let software read a packet that is not yet complete. One buffer is followed by an unowned descriptor. This catches a design that leaves the continue flag set, keeps writing, or skips the interrupt. An 8200-byte packet checks the cut at exactly 8192 bytes across a buffer boundary, where an off-by-one would store an extra byte or none at all. Packets that are dropped, because the base is zero or the descriptor is not owned, must leave memory, the pointer and the interrupt untouched.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned OWN_BIT  = 31;
  localparam int unsigned WRAP_BIT = 30;
  localparam int unsigned CONT_BIT = 27;
  localparam int unsigned DESC_BYTES = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_FILL,
    ST_WR_DATA,
    ST_NXT_RD,
    ST_ST_WR,
    ST_ADV,
    ST_DRAIN,
    ST_FIRST_WR
  } rxr_state_e;
endpackage

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int unsigned LANES = 4,
  localparam int unsigned LW = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [LW-1:0]     lane_i,
  input  logic [7:0]        byte_i,
  output logic [8*LANES-1:0] word_o,
  output logic [LANES-1:0]  be_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_o[8*l +: 8] <= '0;
        be_o[l]          <= 1'b0;
      end else if (clr_i) begin
        be_o[l] <= 1'b0;
      end else if (push_i && lane_i == LW'(l)) begin
        word_o[8*l +: 8] <= byte_i;
        be_o[l]          <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxr_ring_math.sv
module rxr_ring_math
  import rxr_pkg::*;
#(
  parameter int unsigned LEN_W = 13
) (
  input  logic [31:0]      cur_i,
  input  logic [31:0]      base_i,
  input  logic             wrap_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic             crc4_i,
  input  logic             own_next_i,
  output logic [31:0]      next_o,
  output logic [31:0]      stat_last_o,
  output logic [31:0]      stat_chain_o
);
  always_comb begin
    next_o       = wrap_i ? base_i : cur_i + 32'(DESC_BYTES);
    stat_last_o  = 32'(cnt_i) + (crc4_i ? 32'd4 : 32'd2);
    stat_chain_o = 32'(cnt_i);
    if (own_next_i) stat_chain_o[CONT_BIT] = 1'b1;
  end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned MAX_PKT = 8192,
  parameter int unsigned LEN_W   = 13,
  localparam int unsigned TOT_W  = $clog2(MAX_PKT + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cfg_ring_base_i,
  input  logic        cfg_cur_we_i,
  input  logic [31:0] cfg_cur_wdata_i,
  input  logic        cfg_crc4_i,
  output logic [31:0] cur_ptr_o,
  input  logic        s_valid_i,
  input  logic [7:0]  s_data_i,
  input  logic        s_sop_i,
  input  logic        s_eop_i,
  output logic        s_ready_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  mem_be_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ready_i,
  output logic        irq_o
);
  rxr_state_e state_q;
  logic [31:0] cur_q, first_addr_q, buf_q, stat_q, first_stat_q;
  logic [LEN_W-1:0] len_q, nxt_len_q, cnt_q;
  logic [TOT_W-1:0] tot_q;
  logic wrap_q, nxt_wrap_q, nxt_own_q;
  logic first_q, ended_q, eop_q, final_q, drain_fin_q, irq_q;

  logic acc, pk_push, pk_clr;
  logic [31:0] pk_word, next_addr, stat_last, stat_chain;
  logic [3:0]  pk_be;
  logic end_now, full_now, wr_now;

  assign acc       = s_valid_i && s_ready_o;
  assign pk_push   = acc && state_q == ST_FILL;
  assign pk_clr    = state_q == ST_WR_DATA && mem_ready_i;
  assign end_now   = s_eop_i || (tot_q + 1'b1) == TOT_W'(MAX_PKT);
  assign full_now  = (cnt_q + 1'b1) == len_q;
  assign wr_now    = cnt_q[1:0] == 2'd3 || end_now || full_now;
  assign cur_ptr_o = cur_q;
  assign irq_o     = irq_q;

  rxr_byte_packer #(.LANES(4)) i_packer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pk_clr),
    .push_i (pk_push),
    .lane_i (cnt_q[1:0]),
    .byte_i (s_data_i),
    .word_o (pk_word),
    .be_o   (pk_be)
  );

  rxr_ring_math #(.LEN_W(LEN_W)) i_math (
    .cur_i        (cur_q),
    .base_i       (cfg_ring_base_i),
    .wrap_i       (wrap_q),
    .cnt_i        (cnt_q),
    .crc4_i       (cfg_crc4_i),
    .own_next_i   (mem_rdata_i[OWN_BIT]),
    .next_o       (next_addr),
    .stat_last_o  (stat_last),
    .stat_chain_o (stat_chain)
  );

  always_comb begin
    unique case (state_q)
      ST_IDLE:  s_ready_o = s_valid_i && !s_sop_i;
      ST_FILL:  s_ready_o = cnt_q != len_q;
      ST_DRAIN: s_ready_o = 1'b1;
      default:  s_ready_o = 1'b0;
    endcase
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_be_o    = '0;
    unique case (state_q)
      ST_RD0: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q;
      end
      ST_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + 32'd4;
      end
      ST_NXT_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = next_addr;
      end
      ST_WR_DATA: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_q + ((32'(cnt_q) - 32'd1) & ~32'd3);
        mem_wdata_o = pk_word;
        mem_be_o    = pk_be;
      end
      ST_ST_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q;
        mem_wdata_o = stat_q;
        mem_be_o    = 4'hF;
      end
      ST_FIRST_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = first_addr_q;
        mem_wdata_o = first_stat_q;
        mem_be_o    = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cur_q        <= '0;
      first_addr_q <= '0;
      buf_q        <= '0;
      stat_q       <= '0;
      first_stat_q <= '0;
      len_q        <= '0;
      nxt_len_q    <= '0;
      cnt_q        <= '0;
      tot_q        <= '0;
      wrap_q       <= 1'b0;
      nxt_wrap_q   <= 1'b0;
      nxt_own_q    <= 1'b0;
      first_q      <= 1'b0;
      ended_q      <= 1'b0;
      eop_q        <= 1'b0;
      final_q      <= 1'b0;
      drain_fin_q  <= 1'b0;
      irq_q        <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cfg_cur_we_i) cur_q <= cfg_cur_wdata_i;
          if (s_valid_i && s_sop_i) begin
            first_q     <= 1'b1;
            cnt_q       <= '0;
            tot_q       <= '0;
            ended_q     <= 1'b0;
            eop_q       <= 1'b0;
            drain_fin_q <= 1'b0;
            state_q     <= (cfg_ring_base_i == '0) ? ST_DRAIN : ST_RD0;
          end
        end
        ST_RD0: if (mem_ready_i) begin
          len_q        <= mem_rdata_i[LEN_W-1:0];
          wrap_q       <= mem_rdata_i[WRAP_BIT];
          first_addr_q <= cur_q;
          state_q      <= mem_rdata_i[OWN_BIT] ? ST_RD1 : ST_DRAIN;
        end
        ST_RD1: if (mem_ready_i) begin
          buf_q   <= mem_rdata_i;
          state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (cnt_q == len_q) begin
            state_q <= ST_NXT_RD;
          end else if (s_valid_i) begin
            cnt_q   <= cnt_q + 1'b1;
            tot_q   <= tot_q + 1'b1;
            ended_q <= end_now;
            eop_q   <= s_eop_i;
            if (wr_now) state_q <= ST_WR_DATA;
          end
        end
        ST_WR_DATA: if (mem_ready_i) begin
          if (ended_q) begin
            stat_q  <= stat_last;
            final_q <= 1'b1;
            if (first_q) first_stat_q <= stat_last;
            state_q <= first_q ? ST_ADV : ST_ST_WR;
          end else if (cnt_q == len_q) begin
            state_q <= ST_NXT_RD;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_NXT_RD: if (mem_ready_i) begin
          nxt_own_q  <= mem_rdata_i[OWN_BIT];
          nxt_len_q  <= mem_rdata_i[LEN_W-1:0];
          nxt_wrap_q <= mem_rdata_i[WRAP_BIT];
          stat_q     <= stat_chain;
          final_q    <= 1'b0;
          if (first_q) first_stat_q <= stat_chain;
          state_q    <= first_q ? ST_ADV : ST_ST_WR;
        end
        ST_ST_WR: if (mem_ready_i) state_q <= ST_ADV;
        ST_ADV: begin
          cur_q <= next_addr;
          if (final_q) begin
            if (eop_q) begin
              state_q <= ST_FIRST_WR;
            end else begin
              drain_fin_q <= 1'b1;
              state_q     <= ST_DRAIN;
            end
          end else if (nxt_own_q) begin
            len_q   <= nxt_len_q;
            wrap_q  <= nxt_wrap_q;
            cnt_q   <= '0;
            first_q <= 1'b0;
            state_q <= ST_RD1;
          end else begin
            drain_fin_q <= 1'b1;
            state_q     <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (acc && s_eop_i) begin
          state_q <= drain_fin_q ? ST_FIRST_WR : ST_IDLE;
        end
        ST_FIRST_WR: if (mem_ready_i) begin
          irq_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        s_ready_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic [3:0]  mem_be_o,
  input logic        mem_ready_i,
  input logic [31:0] cur_ptr_o,
  input logic        irq_o
);
  a_r11_no_accept_in_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !s_ready_o);

  a_r12_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_wdata_o) && $stable(mem_be_o));

  a_r8_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r8_irq_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_we_o && mem_ready_i));

  a_r4_write_has_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_be_o != 4'h0);

  a_r1_status_full_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_addr_o == cur_ptr_o |-> mem_be_o == 4'hF);
endmodule

bind rxr_ring_writer rxr_ring_writer_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .s_ready_o   (s_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_be_o    (mem_be_o),
  .mem_ready_i (mem_ready_i),
  .cur_ptr_o   (cur_ptr_o),
  .irq_o       (irq_o)
);

// File: tb/test_rxr_ring_writer.sv
module test_rxr_ring_writer;
  localparam int CLK_P = 10;
  localparam logic [31:0] OWN = 32'h8000_0000, WRAP = 32'h4000_0000, CONT = 32'h0800_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ring_base = '0, cur_wdata = '0;
  logic cur_we = 1'b0, crc4 = 1'b0;
  logic s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
  logic [7:0] s_data = '0;
  logic [31:0] cur_ptr, mem_addr, mem_wdata, mem_rdata;
  logic s_ready, mem_req, mem_we, mem_ready, irq;
  logic [3:0] mem_be;

  logic [31:0] mem [0:4095];
  logic [7:0] lfsr = 8'h5A;
  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, acc_cnt = 0, viol = 0, slog_n = 0;
  logic [31:0] slog [0:63];
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rxr_ring_writer i_rxr_ring_writer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ring_base_i(ring_base), .cfg_cur_we_i(cur_we),
    .cfg_cur_wdata_i(cur_wdata), .cfg_crc4_i(crc4), .cur_ptr_o(cur_ptr),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_sop_i(s_sop), .s_eop_i(s_eop), .s_ready_o(s_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_be_o(mem_be), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready), .irq_o(irq)
  );

  assign mem_ready = mem_req && lfsr[0];
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (irq) irq_cnt <= irq_cnt + 1;
    if (s_valid && s_ready && mem_req) viol <= viol + 1;
    if (mem_req && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        if (mem_addr < 32'h400 && slog_n < 64) begin
          slog[slog_n] <= mem_addr;
          slog_n <= slog_n + 1;
        end
      end
    end
  end

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 7 + seed) & 255);
  endfunction

  function automatic logic [7:0] rd_byte(logic [31:0] a);
    return mem[a[13:2]][8*a[1:0] +: 8];
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cur(logic [31:0] v);
    @(negedge clk); cur_we = 1'b1; cur_wdata = v;
    @(negedge clk); cur_we = 1'b0;
  endtask

  task automatic send_pkt(int n, int seed, bit with_sop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = pat(i, seed);
      s_sop = with_sop && i == 0; s_eop = i == n - 1;
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic chk_buf(string req, logic [31:0] a, int first, int n, int seed);
    int bad = 0, bad_i = 0;
    for (int i = 0; i < n; i++)
      if (rd_byte(a + 32'(i)) !== pat(first + i, seed)) begin bad++; bad_i = i; end
    check(bad == 0, req, "buffer bytes", longint'(rd_byte(a + 32'(bad_i))), longint'(pat(first + bad_i, seed)));
  endtask

  task automatic t_reset;
    check(s_ready == 1'b0, "R11", "ready after reset", s_ready, 0);
    check(mem_req == 1'b0, "R12", "req after reset", mem_req, 0);
    check(irq == 1'b0, "R8", "irq after reset", irq, 0);
    check(cur_ptr == 32'h0, "R10", "pointer after reset", cur_ptr, 0);
  endtask

  task automatic t_base_zero;
    int a0, i0;
    set_cur(32'h100);
    mem[32'h100 >> 2] = OWN | 32'd64;
    a0 = acc_cnt; i0 = irq_cnt;
    send_pkt(10, 1, 1);
    check(acc_cnt == a0, "R2", "memory accesses", acc_cnt - a0, 0);
    check(irq_cnt == i0, "R2", "interrupts", irq_cnt - i0, 0);
    check(cur_ptr == 32'h100, "R2", "pointer", cur_ptr, 32'h100);
  endtask

  task automatic t_single;
    int i0;
    ring_base = 32'h100; crc4 = 1'b0;
    mem[32'h100 >> 2] = OWN | 32'd64; mem[32'h104 >> 2] = 32'h1000;
    i0 = irq_cnt;
    send_pkt(10, 3, 1);
    check(mem[32'h100 >> 2] == 32'd12, "R7", "final status crc2", mem[32'h100 >> 2], 12);
    chk_buf("R4", 32'h1000, 0, 10, 3);
    check(rd_byte(32'h100A) == 8'hEE, "R4", "byte past packet", rd_byte(32'h100A), 8'hEE);
    check(cur_ptr == 32'h108, "R10", "pointer advanced", cur_ptr, 32'h108);
    check(irq_cnt == i0 + 1, "R8", "one interrupt", irq_cnt - i0, 1);
  endtask

  task automatic t_not_owned;
    int a0, i0;
    mem[32'h108 >> 2] = 32'd64; mem[32'h10C >> 2] = 32'h1800;
    a0 = acc_cnt; i0 = irq_cnt;
    send_pkt(6, 5, 1);
    check(acc_cnt == a0 + 1, "R3", "only descriptor read", acc_cnt - a0, 1);
    check(irq_cnt == i0, "R3", "interrupts", irq_cnt - i0, 0);
    check(cur_ptr == 32'h108, "R3", "pointer", cur_ptr, 32'h108);
  endtask

  task automatic t_chain_wrap;
    int i0, s0;
    crc4 = 1'b1;
    set_cur(32'h110);
    mem[32'h110 >> 2] = OWN | 32'd6;        mem[32'h114 >> 2] = 32'h1100;
    mem[32'h118 >> 2] = OWN | WRAP | 32'd5; mem[32'h11C >> 2] = 32'h1200;
    mem[32'h100 >> 2] = OWN | 32'd100;      mem[32'h104 >> 2] = 32'h1300;
    i0 = irq_cnt; s0 = slog_n;
    send_pkt(15, 9, 1);
    check(mem[32'h110 >> 2] == (CONT | 32'd6), "R5", "first status", mem[32'h110 >> 2], CONT | 32'd6);
    check(mem[32'h118 >> 2] == (CONT | 32'd5), "R5", "second status", mem[32'h118 >> 2], CONT | 32'd5);
    check(mem[32'h100 >> 2] == 32'd8, "R7", "wrapped last status crc4", mem[32'h100 >> 2], 8);
    check(slog_n == s0 + 3 && slog[s0] == 32'h118 && slog[s0+1] == 32'h100 && slog[s0+2] == 32'h110,
          "R8", "status write order", slog[s0+2], 32'h110);
    chk_buf("R4", 32'h1100, 0, 6, 9);
    chk_buf("R5", 32'h1200, 6, 5, 9);
    chk_buf("R1", 32'h1300, 11, 4, 9);
    check(rd_byte(32'h1106) == 8'hEE, "R4", "partial word lanes", rd_byte(32'h1106), 8'hEE);
    check(cur_ptr == 32'h108, "R5", "pointer after wrap", cur_ptr, 32'h108);
    check(irq_cnt == i0 + 1, "R8", "one interrupt", irq_cnt - i0, 1);
  endtask

  task automatic t_out_of_bufs;
    int i0;
    crc4 = 1'b0;
    set_cur(32'h120);
    mem[32'h120 >> 2] = OWN | 32'd4; mem[32'h124 >> 2] = 32'h1400;
    mem[32'h128 >> 2] = 32'd50;      mem[32'h12C >> 2] = 32'h1500;
    i0 = irq_cnt;
    send_pkt(9, 11, 1);
    check(mem[32'h120 >> 2] == 32'd4, "R6", "bare count status", mem[32'h120 >> 2], 4);
    check(mem[32'h128 >> 2] == 32'd50, "R6", "unowned untouched", mem[32'h128 >> 2], 50);
    check(rd_byte(32'h1404) == 8'hEE && rd_byte(32'h1500) == 8'hEE, "R6", "excess discarded",
          rd_byte(32'h1404), 8'hEE);
    check(cur_ptr == 32'h128, "R6", "pointer at unowned", cur_ptr, 32'h128);
    check(irq_cnt == i0 + 1, "R6", "interrupt", irq_cnt - i0, 1);
  endtask

  task automatic t_truncate;
    int i0;
    set_cur(32'h130);
    mem[32'h130 >> 2] = OWN | 32'd8191; mem[32'h134 >> 2] = 32'h1000;
    mem[32'h138 >> 2] = OWN | 32'd100;  mem[32'h13C >> 2] = 32'h3000;
    i0 = irq_cnt;
    send_pkt(8200, 13, 1);
    check(mem[32'h130 >> 2] == (CONT | 32'd8191), "R9", "full buffer status", mem[32'h130 >> 2], CONT | 32'd8191);
    check(mem[32'h138 >> 2] == 32'd3, "R9", "one byte plus crc", mem[32'h138 >> 2], 3);
    chk_buf("R9", 32'h1000, 0, 8191, 13);
    check(rd_byte(32'h3000) == pat(8191, 13) && rd_byte(32'h3001) == 8'hEE, "R9", "cut point",
          rd_byte(32'h3001), 8'hEE);
    check(cur_ptr == 32'h140, "R10", "pointer", cur_ptr, 32'h140);
    check(irq_cnt == i0 + 1, "R9", "interrupt", irq_cnt - i0, 1);
  endtask

  task automatic t_stray;
    int a0, i0;
    a0 = acc_cnt; i0 = irq_cnt;
    send_pkt(5, 17, 0);
    check(acc_cnt == a0, "R11", "stray bytes no access", acc_cnt - a0, 0);
    check(irq_cnt == i0 && cur_ptr == 32'h140, "R11", "stray bytes no effect", cur_ptr, 32'h140);
    check(viol == 0, "R11", "byte accepted during memory access", viol, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'hEEEE_EEEE;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_base_zero();
    t_single();
    t_not_owned();
    t_chain_wrap();
    t_out_of_bufs();
    t_truncate();
    t_stray();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule